// File: doc/BRIEF.md
# Sleep Mode Controller

This block decides when a small processor core may sleep and when it must wake. The CPU selects one of four sleep depths with a 2-bit field, sets a sleep-enable bit, and issues a one-cycle request pulse. The controller then removes the clock enables for each domain that the chosen depth stops. These domains are the CPU, the I/O and peripheral group, the ADC and an asynchronous timer. While the core sleeps, the controller watches five wake inputs. It returns the core to the active state only when an input that the current depth accepts is asserted.

Every wake input runs through a two-flop synchronizer on the controller's own free-running clock. Detection therefore never depends on a domain clock that may be gated. Inputs that the current depth does not accept do not wake the core. They still show on a pending output, and the controller never clears them. When the core wakes, all clock enables come back in one cycle, and a one-cycle wake pulse is raised in that same cycle.

Top module: `sleep_ctrl`

## Requirements
- R1: `state_o` reads 3'b000 while active and {1'b1, mode} while asleep. After reset the state is active with `en_cpu`, `en_io` and `en_tmr` at 1 and `en_adc` equal to `adc_en`, and these active enables hold whenever the state is active.
- R2: A `sleep_req` pulse with `sleep_en`=1, sampled at a clock edge while active, moves the state to sleep in the `mode` given at that edge. `en_cpu` is 0 in every sleep mode.
- R3: A `sleep_req` pulse with `sleep_en`=0 leaves the state active.
- R4: Idle (mode 2'b00) keeps `en_io` and `en_tmr` at 1, with `en_adc` equal to `adc_en`. Any of the five wake inputs wakes the core.
- R5: ADC noise reduction (mode 2'b01) keeps `en_io`, `en_adc` and `en_tmr` at 1. Only `wk_adc` or `wk_ext` wakes the core.
- R6: Power-save (mode 2'b10) keeps only `en_tmr` at 1. Only `wk_tmr` or `wk_ext` wakes the core.
- R7: Power-down (mode 2'b11) sets all four enables to 0. Only `wk_ext` or `wk_wdt` wakes the core.
- R8: A wake input that the current mode does not accept leaves the state asleep. Its synchronized level shows on `pend_o`, with bit order [0] irq, [1] adc, [2] tmr, [3] ext, [4] wdt.
- R9: A sleep request is ignored while a wake input that the requested mode accepts is already visible on `pend_o`.
- R10: An accepted wake input asserted before clock edge k makes the state active after edge k+2. Every enable is restored in that cycle, and `wake_pulse` is 1 for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Active-low reset |
| mode | input | 2 | Requested sleep depth |
| sleep_en | input | 1 | Permits sleep requests |
| sleep_req | input | 1 | One-cycle request to sleep |
| adc_en | input | 1 | ADC clock wanted while active or in Idle |
| wk_irq | input | 1 | Generic interrupt request |
| wk_adc | input | 1 | ADC conversion complete |
| wk_tmr | input | 1 | Asynchronous timer event |
| wk_ext | input | 1 | External interrupt |
| wk_wdt | input | 1 | Watchdog event |
| en_cpu | output | 1 | CPU clock enable |
| en_io | output | 1 | I/O and peripheral clock enable |
| en_adc | output | 1 | ADC clock enable |
| en_tmr | output | 1 | Asynchronous timer clock enable |
| wake_pulse | output | 1 | One-cycle pulse on return to active |
| pend_o | output | 5 | Synchronized wake input levels |
| state_o | output | 3 | Active or current sleep mode |

## Verification
If the stored mode is wrong, the enable pattern on the four clock-enable outputs is wrong in the first sleeping cycle. The accepted wake set is wrong from then on as well. A faulty wake mask shows up three edges after a wake input rises: the state stays asleep for an input the mode should accept, or returns to active for one it should reject. A synchronizer that is too short or too long moves the return to active and the wake pulse one cycle off the expected edge. A damaged pulse register either misses that cycle or stays high into the next one.

// File: rtl/sleep_ctrl.sv
module sleep_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       sleep_en,
  input  logic       sleep_req,
  input  logic       adc_en,
  input  logic       wk_irq,
  input  logic       wk_adc,
  input  logic       wk_tmr,
  input  logic       wk_ext,
  input  logic       wk_wdt,
  output logic       en_cpu,
  output logic       en_io,
  output logic       en_adc,
  output logic       en_tmr,
  output logic       wake_pulse,
  output logic [4:0] pend_o,
  output logic [2:0] state_o
);

  localparam int NSRC = 5;

  logic [NSRC-1:0] sync_q [SYNC_STAGES];
  logic            asleep;
  logic [1:0]      mode_q;

  function automatic logic [NSRC-1:0] accept(input logic [1:0] m);
    case (m)
      2'b00:   accept = 5'b11111;
      2'b01:   accept = 5'b01010;
      2'b10:   accept = 5'b01100;
      default: accept = 5'b11000;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= {wk_wdt, wk_ext, wk_tmr, wk_adc, wk_irq};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign pend_o = sync_q[SYNC_STAGES-1];

  wire go_sleep = !asleep && sleep_req && sleep_en && ((pend_o & accept(mode)) == '0);
  wire go_wake  = asleep && ((pend_o & accept(mode_q)) != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep     <= 1'b0;
      mode_q     <= 2'b00;
      wake_pulse <= 1'b0;
    end else begin
      wake_pulse <= go_wake;
      if (go_sleep) begin
        asleep <= 1'b1;
        mode_q <= mode;
      end else if (go_wake) begin
        asleep <= 1'b0;
      end
    end
  end

  wire light = asleep && !mode_q[1];

  assign state_o = asleep ? {1'b1, mode_q} : 3'b000;
  assign en_cpu  = !asleep;
  assign en_io   = !asleep || light;
  assign en_adc  = asleep ? (mode_q == 2'b01 || (mode_q == 2'b00 && adc_en)) : adc_en;
  assign en_tmr  = !asleep || mode_q != 2'b11;

endmodule

// File: rtl/sleep_ctrl_chk.sv
module sleep_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_en,
  input logic       sleep_req,
  input logic       adc_en,
  input logic       en_cpu,
  input logic       en_io,
  input logic       en_adc,
  input logic       en_tmr,
  input logic       wake_pulse,
  input logic [2:0] state_o
);

  p_cpu_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state_o[2] |-> !en_cpu);

  p_active_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 3'b000 |-> (en_cpu && en_io && en_tmr && en_adc == adc_en));

  p_no_enable_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'b000 && sleep_req && !sleep_en) |=> state_o == 3'b000);

  p_psave_r6: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 3'b110 |-> (en_tmr && !en_io && !en_adc));

  p_pdown_r7: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 3'b111 |-> !(en_io || en_adc || en_tmr));

  p_wake_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(state_o[2]) |-> wake_pulse);

  p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

endmodule

bind sleep_ctrl sleep_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .sleep_req(sleep_req),
  .adc_en(adc_en), .en_cpu(en_cpu), .en_io(en_io), .en_adc(en_adc),
  .en_tmr(en_tmr), .wake_pulse(wake_pulse), .state_o(state_o)
);

// File: tb/sleep_ctrl_test.sv
module sleep_ctrl_test;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 0;
  logic sleep_en = 0, sleep_req = 0, adc_en = 0;
  logic [4:0] wk = 0;
  logic en_cpu, en_io, en_adc, en_tmr, wake_pulse;
  logic [4:0] pend_o;
  logic [2:0] state_o;
  int vectors = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;

  sleep_ctrl uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sleep_en(sleep_en), .sleep_req(sleep_req),
    .adc_en(adc_en), .wk_irq(wk[0]), .wk_adc(wk[1]), .wk_tmr(wk[2]), .wk_ext(wk[3]),
    .wk_wdt(wk[4]), .en_cpu(en_cpu), .en_io(en_io), .en_adc(en_adc), .en_tmr(en_tmr),
    .wake_pulse(wake_pulse), .pend_o(pend_o), .state_o(state_o)
  );

  function automatic logic [4:0] ok_mask(input int m);
    case (m)
      0: return 5'b11111;
      1: return 5'b01010;
      2: return 5'b01100;
      default: return 5'b11000;
    endcase
  endfunction

  function automatic logic [3:0] exp_en(input int m, input logic ae);
    case (m)
      0: return {1'b0, 1'b1, ae, 1'b1};
      1: return 4'b0111;
      2: return 4'b0001;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic request(input int m, input logic en);
    mode = m[1:0]; sleep_en = en; sleep_req = 1;
    step(1);
    sleep_req = 0;
  endtask

  task automatic check_active(input string req);
    chk(req, {state_o, en_cpu, en_io, en_adc, en_tmr},
        {3'b000, 1'b1, 1'b1, adc_en, 1'b1});
  endtask

  task automatic wake_by_ext;
    wk[3] = 1; step(3);
    chk("R10", {state_o, wake_pulse}, {3'b000, 1'b1});
    check_active("R10");
    step(1);
    chk("R10", wake_pulse, 1'b0);
    wk = 0; step(3);
  endtask

  initial begin
    #(PERIOD * 20000);
    errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    step(2);
    check_active("R1");
    rst_n = 1;
    step(2);

    request(3, 0);
    chk("R3", state_o, 3'b000);
    step(1);
    chk("R3", state_o, 3'b000);

    for (int ae = 0; ae < 2; ae++) begin
      for (int m = 0; m < 4; m++) begin
        for (int s = 0; s < 5; s++) begin
          adc_en = ae[0];
          step(1);
          request(m, 1);
          chk("R2", state_o, {1'b1, m[1:0]});
          chk(m == 0 ? "R4" : m == 1 ? "R5" : m == 2 ? "R6" : "R7",
              {en_cpu, en_io, en_adc, en_tmr}, exp_en(m, adc_en));
          wk[s] = 1;
          step(3);
          if (ok_mask(m)[s]) begin
            chk("R10", {state_o, wake_pulse}, {3'b000, 1'b1});
            check_active("R10");
            step(1);
            chk("R10", wake_pulse, 1'b0);
            wk = 0; step(3);
          end else begin
            chk("R8", {state_o, pend_o}, {1'b1, m[1:0], 5'(1 << s)});
            chk("R8", {en_cpu, en_io, en_adc, en_tmr}, exp_en(m, adc_en));
            wk = 0; step(3);
            chk("R8", state_o, {1'b1, m[1:0]});
            wake_by_ext();
          end
          chk("R8", pend_o, 5'b00000);
        end
      end
    end

    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 5; s++) begin
        wk[s] = 1; step(3);
        request(m, 1);
        if (ok_mask(m)[s]) begin
          chk("R9", state_o, 3'b000);
          wk = 0; step(3);
        end else begin
          chk("R9", state_o, {1'b1, m[1:0]});
          wk = 0; step(3);
          wake_by_ext();
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule